// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block is the digital controller that sits beside an analog-to-digital converter core. Software configures it through a small register bus: a control register that holds the free-running enable and the accumulation length, a command register with a start bit, a channel select, an event-start enable, an interrupt enable and a ready flag, plus a read-only result register. A conversion starts when software writes the start bit or when a rising edge arrives on the event input. The block then requests samples from the core one at a time over a start/done handshake, adds them into an accumulator, and publishes the sum once the whole sequence is in.

The start bit doubles as a busy indicator. It is set by software or by an event, and cleared by hardware when a single conversion ends. In free-running mode a finished conversion immediately launches the next one, and this continues until software clears the free-running enable. The channel and accumulation length are captured when each conversion starts, so software may change either register at any time without disturbing the conversion that is already running. Every completion raises a ready flag, and that flag drives the interrupt request when the local enable and a global enable input also allow it.

Top module: `adc_start_seq`

## Requirements
- R1: Writing 1 to bit 0 of the command register (address 1) while idle starts a conversion, and that bit reads 1 until the conversion completes. Reset leaves it at 0.
- R2: When free-running mode (control register address 0, bit 0) is 0, hardware clears the command bit 0 on completion.
- R3: The channel select register (address 2, bits 4:0) is captured when a conversion starts. A write to it during a conversion leaves every sample of that conversion on the old channel, and the next conversion uses the new value.
- R4: Control register bits 3:1 hold k, the base-2 logarithm of the number of samples summed per result, where k = 0..6 gives 1 to 64 samples and a value of 7 is treated as 6. The result register (address 6) holds the full 16-bit sum without overflow, and completion happens only after the last sample.
- R5: Every completion sets the ready flag (flag register address 5, bit 0), whether or not its interrupt is enabled. The flag is 0 after reset.
- R6: The interrupt output is 1 exactly when the ready flag, the interrupt enable bit (address 4, bit 0) and the global enable input are all 1.
- R7: When the event enable bit (address 3, bit 0) is 1, a rising edge on the event input starts a conversion. A level held high does not start another one, and an edge has no effect while the enable bit is 0.
- R8: In free-running mode, a write of the start bit begins the first conversion and each completion starts the next at once. The start bit stays 1, and every completion sets the ready flag.
- R9: Writing 1 to flag bit 0, or reading the result register, clears the ready flag. When a clear and a completion fall in the same cycle, the flag ends up set.
- R10: A start request, whether from the bus or an event, that arrives while a conversion is in progress is dropped. It causes no additional conversion.
- R11: Clearing the free-running bit during a conversion lets that conversion complete. After it, no further conversion starts and the start bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of the result clears the flag) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| evt_in | input | 1 | Event trigger, edge sensitive |
| gie | input | 1 | Global interrupt enable |
| conv_start | output | 1 | One-cycle request to the converter core for one sample |
| conv_chan | output | 5 | Channel captured for the running conversion |
| conv_done | input | 1 | One-cycle pulse from the core, with a sample valid |
| conv_data | input | 10 | Sample returned by the core |
| result | output | 16 | Last accumulated sum |
| conv_complete | output | 1 | One-cycle pulse when a result is published |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land in the same cycle: the ready flag being set by a completion, and software clearing it, either by writing 1 to the flag or by reading the result. The bench provokes this by waiting for the core model to raise its done pulse for the final sample, then driving the clear in that same cycle so the write or read and the completion share one clock edge. The flag is then read back, and it must still be 1. The scoreboard also matches the completion against its expected channel and sum.

// File: rtl/adc_start_seq.sv
module adc_start_seq #(
  parameter int SAMPLE_W     = 10,
  parameter int CH_W         = 5,
  parameter int ACC_LOG2_MAX = 6,
  parameter int ADDR_W       = 3,
  localparam int ACC_W = SAMPLE_W + ACC_LOG2_MAX,
  localparam int SEL_W = $clog2(ACC_LOG2_MAX + 1),
  localparam int CNT_W = ACC_LOG2_MAX + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ACC_W-1:0]  bus_wdata,
  output logic [ACC_W-1:0]  bus_rdata,
  input  logic              evt_in,
  input  logic              gie,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [SAMPLE_W-1:0] conv_data,
  output logic [ACC_W-1:0]  result,
  output logic              conv_complete,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_CTRL = 0, A_CMD = 1, A_CHAN = 2, A_EVT = 3,
                                A_IEN = 4, A_FLAG = 5, A_RES = 6;

  logic              free_run, busy, evt_en, irq_en, flag, evt_q;
  logic [SEL_W-1:0]  acc_sel, sel_run, sel_eff;
  logic [CH_W-1:0]   ch_sel;
  logic [CNT_W-1:0]  cnt, tgt_m1;
  logic [ACC_W-1:0]  sum;
  logic              start_req, launch, last, restart, flag_clr;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata[ACC_W-1:CH_W];

  assign sel_eff   = (acc_sel > SEL_W'(ACC_LOG2_MAX)) ? SEL_W'(ACC_LOG2_MAX) : acc_sel;
  assign tgt_m1    = (CNT_W'(1) << sel_run) - CNT_W'(1);
  assign start_req = (bus_wr && bus_addr == A_CMD && bus_wdata[0]) || (evt_en && evt_in && !evt_q);
  assign launch    = start_req && !busy;
  assign last      = busy && conv_done && (cnt == tgt_m1);
  assign restart   = last && free_run;
  assign flag_clr  = (bus_wr && bus_addr == A_FLAG && bus_wdata[0]) || (bus_rd && bus_addr == A_RES);
  assign irq       = flag && irq_en && gie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_run <= 1'b0; acc_sel <= '0; ch_sel <= '0; evt_en <= 1'b0; irq_en <= 1'b0;
      busy <= 1'b0; flag <= 1'b0; evt_q <= 1'b0; sel_run <= '0; cnt <= '0; sum <= '0;
      conv_chan <= '0; result <= '0; conv_start <= 1'b0; conv_complete <= 1'b0;
    end else begin
      evt_q         <= evt_in;
      conv_start    <= 1'b0;
      conv_complete <= 1'b0;
      if (bus_wr) begin
        case (bus_addr)
          A_CTRL: begin free_run <= bus_wdata[0]; acc_sel <= bus_wdata[SEL_W:1]; end
          A_CHAN: ch_sel <= bus_wdata[CH_W-1:0];
          A_EVT:  evt_en <= bus_wdata[0];
          A_IEN:  irq_en <= bus_wdata[0];
          default: ;
        endcase
      end
      if (launch || restart) begin
        busy       <= 1'b1;
        conv_chan  <= ch_sel;
        sel_run    <= sel_eff;
        cnt        <= '0;
        sum        <= '0;
        conv_start <= 1'b1;
      end else if (busy && conv_done) begin
        if (last) begin
          busy <= 1'b0;
        end else begin
          cnt        <= cnt + CNT_W'(1);
          sum        <= sum + ACC_W'(conv_data);
          conv_start <= 1'b1;
        end
      end
      if (last) begin
        result        <= sum + ACC_W'(conv_data);
        conv_complete <= 1'b1;
      end
      if (last)          flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin bus_rdata[0] = free_run; bus_rdata[SEL_W:1] = acc_sel; end
      A_CMD:  bus_rdata[0] = busy;
      A_CHAN: bus_rdata[CH_W-1:0] = ch_sel;
      A_EVT:  bus_rdata[0] = evt_en;
      A_IEN:  bus_rdata[0] = irq_en;
      A_FLAG: bus_rdata[0] = flag;
      A_RES:  bus_rdata = result;
      default: ;
    endcase
  end

  a_r1_request_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);
  a_r3_channel_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !conv_complete |-> $stable(conv_chan));
  a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt <= tgt_m1);
  a_r9_flag_with_complete: assert property (@(posedge clk) disable iff (!rst_n)
    conv_complete |-> flag);
  a_r10_no_extra_request: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && busy && !$past(conv_done) |-> !conv_start);
  a_r8_freerun_stays_busy: assert property (@(posedge clk) disable iff (!rst_n)
    conv_complete && $past(free_run) |-> busy);

endmodule

// File: tb/tb_adc_start_seq.sv
module tb_adc_start_seq;
  localparam int ACC_W = 16;
  localparam int CH_W  = 5;
  localparam int LAT   = 3;
  localparam logic [2:0] A_CTRL = 0, A_CMD = 1, A_CHAN = 2, A_EVT = 3,
                         A_IEN = 4, A_FLAG = 5, A_RES = 6;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0, evt_in = 0, gie = 0, conv_done = 0;
  logic [2:0] bus_addr = '0;
  logic [ACC_W-1:0] bus_wdata = '0;
  logic [9:0] conv_data = '0;
  logic [ACC_W-1:0] bus_rdata, result;
  logic conv_start, conv_complete, irq;
  logic [CH_W-1:0] conv_chan;

  int n_checks = 0, n_err = 0, n_done = 0;
  logic [CH_W+ACC_W-1:0] exp_q[$];

  adc_start_seq dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .gie(gie),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_data(conv_data), .result(result), .conv_complete(conv_complete), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [9:0] smp(input logic [CH_W-1:0] ch);
    return (ch == 5'd31) ? 10'd1023 : 10'(ch * 16 + 7);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter core model: fixed latency, sample value depends on channel
  int lat_cnt = 0;
  logic [CH_W-1:0] core_ch = '0;
  always @(negedge clk) begin
    if (conv_done) conv_done = 1'b0;
    if (lat_cnt > 0) begin
      lat_cnt--;
      if (lat_cnt == 0) begin conv_data = smp(core_ch); conv_done = 1'b1; end
    end else if (conv_start) begin
      core_ch = conv_chan;
      lat_cnt = LAT;
    end
  end

  // monitor: channel of every sample request and each published sum
  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_start && exp_q.size() > 0)
        check(conv_chan == exp_q[0][ACC_W+CH_W-1:ACC_W], "R3 sample channel",
              conv_chan, exp_q[0][ACC_W+CH_W-1:ACC_W]);
      if (conv_complete) begin
        n_done++;
        if (exp_q.size() == 0) check(0, "R10 unexpected completion", 1, 0);
        else begin
          logic [CH_W+ACC_W-1:0] it;
          it = exp_q.pop_front();
          check(result == it[ACC_W-1:0], "R4 accumulated result", result, it[ACC_W-1:0]);
        end
      end
    end
  end

  task automatic expect_conv(input logic [CH_W-1:0] ch, input int n);
    exp_q.push_back({ch, ACC_W'(n * smp(ch))});
  endtask

  task automatic bus_write(input logic [2:0] a, input int d);
    bus_wr = 1; bus_addr = a; bus_wdata = ACC_W'(d);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(input logic [2:0] a, output int d);
    bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wait_done(input int k);
    while (n_done < k) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int d, base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    bus_read(A_CMD, d);  check(d == 0, "R1 reset start bit", d, 0);
    bus_read(A_FLAG, d); check(d == 0, "R5 reset flag", d, 0);
    check(irq == 0, "R6 reset irq", irq, 0);

    // R1/R2 single conversion, one sample
    gie = 1;
    bus_write(A_IEN, 1); bus_write(A_CTRL, 0); bus_write(A_CHAN, 5);
    expect_conv(5, 1);
    bus_write(A_CMD, 1);
    bus_read(A_CMD, d); check(d == 1, "R1 busy during conversion", d, 1);
    wait_done(1);
    bus_read(A_CMD, d); check(d == 0, "R2 start bit cleared", d, 0);
    check(irq == 1, "R6 irq with all enables", irq, 1);
    bus_read(A_RES, d); check(d == 5 * 16 + 7, "R9 result read", d, 87);
    check(irq == 0, "R9 read of result clears flag", irq, 0);

    // R4 four samples, then W1C clear
    bus_write(A_CHAN, 9); bus_write(A_CTRL, 2 << 1);
    expect_conv(9, 4);
    bus_write(A_CMD, 1);
    wait_done(2);
    bus_write(A_FLAG, 1);
    bus_read(A_FLAG, d); check(d == 0, "R9 write-one clear", d, 0);

    // R4 code 7 acts as 64 samples, full scale
    bus_write(A_CHAN, 31); bus_write(A_CTRL, 7 << 1);
    expect_conv(31, 64);
    bus_write(A_CMD, 1);
    wait_done(3);
    bus_read(A_RES, d); check(d == 65472, "R4 64-sample sum no overflow", d, 65472);

    // R3 channel write during conversion
    bus_write(A_CHAN, 3); bus_write(A_CTRL, 2 << 1);
    expect_conv(3, 4);
    bus_write(A_CMD, 1);
    repeat (3) @(negedge clk);
    bus_write(A_CHAN, 12);
    wait_done(4);
    bus_write(A_CTRL, 0);
    expect_conv(12, 1);
    bus_write(A_CMD, 1);
    wait_done(5);
    bus_read(A_RES, d); check(d == 12 * 16 + 7, "R3 next conversion uses new channel", d, 199);

    // R5/R6 polling with interrupt disabled, global gating
    bus_write(A_IEN, 0); bus_write(A_CHAN, 1);
    expect_conv(1, 1);
    bus_write(A_CMD, 1);
    wait_done(6);
    check(irq == 0, "R6 irq off when enable bit 0", irq, 0);
    bus_read(A_FLAG, d); check(d == 1, "R5 flag set with irq disabled", d, 1);
    bus_write(A_IEN, 1);
    check(irq == 1, "R6 irq after enable", irq, 1);
    gie = 0; #1;
    check(irq == 0, "R6 irq off when global enable 0", irq, 0);
    gie = 1;
    bus_write(A_FLAG, 1);

    // R10 start while busy is dropped
    bus_write(A_CHAN, 6); bus_write(A_CTRL, 2 << 1);
    expect_conv(6, 4);
    bus_write(A_CMD, 1);
    repeat (2) @(negedge clk);
    bus_write(A_CMD, 1);
    wait_done(7);
    repeat (40) @(negedge clk);
    check(n_done == 7, "R10 no queued conversion", n_done, 7);
    bus_read(A_CMD, d); check(d == 0, "R10 idle after drop", d, 0);
    bus_write(A_FLAG, 1);

    // R7 event start
    bus_write(A_CTRL, 0); bus_write(A_CHAN, 2);
    evt_in = 1; repeat (5) @(negedge clk); evt_in = 0;
    repeat (10) @(negedge clk);
    check(n_done == 7, "R7 edge ignored when disabled", n_done, 7);
    bus_write(A_EVT, 1);
    expect_conv(2, 1);
    evt_in = 1;
    wait_done(8);
    repeat (30) @(negedge clk);
    check(n_done == 8, "R7 held level no retrigger", n_done, 8);
    bus_read(A_CMD, d); check(d == 0, "R7 idle while held high", d, 0);
    evt_in = 0; repeat (2) @(negedge clk);
    expect_conv(2, 1);
    evt_in = 1;
    wait_done(9);
    check(n_done == 9, "R7 second rising edge", n_done, 9);
    evt_in = 0;
    bus_write(A_EVT, 0); bus_write(A_FLAG, 1);

    // R9 completion and clear in the same cycle
    bus_write(A_CHAN, 7);
    expect_conv(7, 1);
    bus_write(A_CMD, 1);
    @(posedge conv_done);
    bus_wr = 1; bus_addr = A_FLAG; bus_wdata = 1;
    @(negedge clk); bus_wr = 0;
    bus_read(A_FLAG, d); check(d == 1, "R9 set wins over write clear", d, 1);
    bus_write(A_FLAG, 1);
    expect_conv(7, 1);
    bus_write(A_CMD, 1);
    @(posedge conv_done);
    bus_rd = 1; bus_addr = A_RES;
    @(negedge clk); bus_rd = 0;
    bus_read(A_FLAG, d); check(d == 1, "R9 set wins over result read", d, 1);
    bus_write(A_FLAG, 1);

    // R8/R11 free running and stop
    bus_write(A_CHAN, 4);
    for (int i = 0; i < 6; i++) expect_conv(4, 1);
    base = n_done;
    bus_write(A_CTRL, 1);
    bus_write(A_CMD, 1);
    wait_done(base + 2);
    bus_read(A_CMD, d); check(d == 1, "R8 start bit held in free run", d, 1);
    bus_read(A_FLAG, d); check(d == 1, "R8 flag set by free-run completion", d, 1);
    wait_done(base + 3);
    bus_write(A_CTRL, 0);
    repeat (60) @(negedge clk);
    check(n_done == base + 4, "R11 running conversion finishes then stops", n_done, base + 4);
    bus_read(A_CMD, d); check(d == 0, "R11 start bit cleared after stop", d, 0);
    exp_q.delete();

    finish_run();
  end
endmodule